// File: doc/BRIEF.md
# Thread-Partitioned LRU Victim Selector

This block picks replacement ways for an 8-way set-associative L1 data cache that two hardware threads share. Thread 0 is the high-priority primary thread and thread 1 is the low-priority secondary thread. Each cycle the cache may present one access. An access carries a set index, the thread number, and either a hit with its way number or a miss. The block keeps a full recency order of all ways in every set.

A 3-bit split code decides how many ways belong to the primary thread. The primary thread owns the low-numbered ways and the secondary thread owns the rest. On a miss, the block returns the least recently used way among the ways that the requesting thread owns. It then treats that way as just filled. If the thread owns no way, the block flags the miss as non-allocating and returns no victim.

The split code may change between any two accesses. Recency state is never cleared when this happens. A line that now sits in the other thread's ways stays readable until normal replacement evicts it.

Top module: `wp_lru_repl`

## Requirements
- R1: After reset both `vic_valid` and `no_alloc` are low, and every set orders its ways so that way 7 is least recent and way 0 most recent. The first primary miss in any set with split code 0 therefore returns way 7.
- R2: The split code maps to a primary way count as follows: 0→8, 1→7, 2→6, 3→5, 4→4, 5→2. The primary thread (thread 0) owns ways 0 to count−1, and the secondary thread (thread 1) owns the remaining ways.
- R3: On a miss, `vic_way` is the way with the oldest use among the ways that the requesting thread owns in that set.
- R4: A hit by either thread, in any way, makes that way the most recent in its set. This holds even when the other thread owns the way.
- R5: A miss that allocates makes the returned victim the most recent way in its set.
- R6: When the requesting thread owns no way, `no_alloc` is raised, `vic_valid` stays low, and the set's recency order is left unchanged.
- R7: Split codes 6 and 7 behave exactly like code 0.
- R8: `vic_valid`, `vic_way` and `no_alloc` are registered and appear on the cycle after the access. Both flags are low after a hit or an idle cycle.
- R9: Recency state of one set is not changed by accesses to another set.
- R10: A change of split code leaves all recency state in place, and the next miss uses the new split.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is present this cycle |
| acc_set | input | SET_W | Set index of the access |
| acc_thread | input | 1 | 0 = primary thread, 1 = secondary thread |
| acc_hit | input | 1 | 1 = hit in `acc_way`, 0 = miss |
| acc_way | input | WAY_W | Way that hit (ignored on a miss) |
| split | input | 3 | Partition code, see R2 and R7 |
| vic_valid | output | 1 | A victim way is returned for the last access |
| vic_way | output | WAY_W | Victim way |
| no_alloc | output | 1 | The last miss had no way to allocate |

## Verification
The hardest case to reach is a victim chosen from a recency order that was built up under one split and is then read under another. In that case, hits by the other thread into foreign ways have reordered the set before the change. To reach it, the stimulus runs a long pseudo-random mix of hits and misses from both threads over four sets without any reset. It steps through all eight split codes in turn. Every miss is compared against a timestamp model of last use.

// File: rtl/wp_lru_repl.sv
module wp_lru_repl #(
  parameter int WAYS  = 8,
  parameter int SETS  = 16,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [SET_W-1:0] acc_set,
  input  logic             acc_thread,
  input  logic             acc_hit,
  input  logic [WAY_W-1:0] acc_way,
  input  logic [2:0]       split,
  output logic             vic_valid,
  output logic [WAY_W-1:0] vic_way,
  output logic             no_alloc
);

  logic [WAY_W-1:0] age_q [SETS][WAYS];
  logic [WAY_W:0]   pcnt;
  logic [WAYS-1:0]  own;
  logic [WAY_W-1:0] best_way, best_age, upd_way, upd_age;
  logic             found, do_upd;

  function automatic logic [WAY_W:0] prim_count(input logic [2:0] code);
    case (code)
      3'd1:    return (WAY_W+1)'(WAYS - 1);
      3'd2:    return (WAY_W+1)'(WAYS - 2);
      3'd3:    return (WAY_W+1)'(WAYS - 3);
      3'd4:    return (WAY_W+1)'(WAYS / 2);
      3'd5:    return (WAY_W+1)'(WAYS / 4);
      default: return (WAY_W+1)'(WAYS);
    endcase
  endfunction

  assign pcnt = prim_count(split);

  always_comb begin
    found    = 1'b0;
    best_way = '0;
    best_age = '0;
    for (int w = 0; w < WAYS; w++) begin
      own[w] = acc_thread ? ((WAY_W+1)'(w) >= pcnt) : ((WAY_W+1)'(w) < pcnt);
      if (own[w] && (!found || age_q[acc_set][w] > best_age)) begin
        found    = 1'b1;
        best_way = WAY_W'(w);
        best_age = age_q[acc_set][w];
      end
    end
  end

  assign do_upd  = acc_valid && (acc_hit || found);
  assign upd_way = acc_hit ? acc_way : best_way;
  assign upd_age = age_q[acc_set][upd_way];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_W'(w);
      vic_valid <= 1'b0;
      vic_way   <= '0;
      no_alloc  <= 1'b0;
    end else begin
      if (do_upd)
        for (int w = 0; w < WAYS; w++)
          if (WAY_W'(w) == upd_way)          age_q[acc_set][w] <= '0;
          else if (age_q[acc_set][w] < upd_age) age_q[acc_set][w] <= age_q[acc_set][w] + 1'b1;
      vic_valid <= acc_valid && !acc_hit && found;
      vic_way   <= best_way;
      no_alloc  <= acc_valid && !acc_hit && !found;
    end
  end

  AST_VICTIM_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    vic_valid |-> ((WAY_W+1)'(vic_way) < prim_count($past(split))) != $past(acc_thread)); // R2
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(vic_valid && no_alloc)); // R6
  AST_RESP_NEEDS_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (vic_valid || no_alloc) |-> $past(acc_valid && !acc_hit)); // R8
  AST_NOALLOC_SECONDARY: assert property (@(posedge clk) disable iff (!rst_n)
    no_alloc |-> ($past(acc_thread) && prim_count($past(split)) == (WAY_W+1)'(WAYS))); // R6
  AST_HIT_BECOMES_MRU: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_hit) |=> age_q[$past(acc_set)][$past(acc_way)] == '0); // R4
  AST_VICTIM_BECOMES_MRU: assert property (@(posedge clk) disable iff (!rst_n)
    vic_valid |-> age_q[$past(acc_set)][vic_way] == '0); // R5

endmodule

// File: tb/test_wp_lru_repl.sv
module test_wp_lru_repl;
  localparam int CLK_PERIOD = 10;
  localparam int WAYS = 8, SETS = 16, WAY_W = 3, SET_W = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic acc_valid = 1'b0, acc_thread = 1'b0, acc_hit = 1'b0;
  logic [SET_W-1:0] acc_set = '0;
  logic [WAY_W-1:0] acc_way = '0;
  logic [2:0] split = '0;
  logic vic_valid, no_alloc;
  logic [WAY_W-1:0] vic_way;

  int checks = 0, failures = 0;
  int stamp [SETS][WAYS];
  int now = WAYS;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wp_lru_repl #(.WAYS(WAYS), .SETS(SETS)) i_wp_lru_repl (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_set(acc_set),
    .acc_thread(acc_thread), .acc_hit(acc_hit), .acc_way(acc_way),
    .split(split), .vic_valid(vic_valid), .vic_way(vic_way), .no_alloc(no_alloc));

  function automatic int pcount(int code);
    case (code)
      1: return 7; 2: return 6; 3: return 5; 4: return 4; 5: return 2;
      default: return 8;
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic access(int s, int t, bit h, int w, int code, string req);
    int p, best, ev, ena, ew;
    p = pcount(code);
    best = -1;
    for (int k = 0; k < WAYS; k++)
      if (((t == 0) ? (k < p) : (k >= p)) && (best < 0 || stamp[s][k] < stamp[s][best])) best = k;
    @(negedge clk);
    acc_valid = 1; acc_set = SET_W'(s); acc_thread = t[0]; acc_hit = h;
    acc_way = WAY_W'(w); split = 3'(code);
    ev = 0; ena = 0; ew = 0;
    if (h) stamp[s][w] = now++;
    else if (best < 0) ena = 1;
    else begin ev = 1; ew = best; stamp[s][best] = now++; end
    @(posedge clk); #1;
    check({req, " vic_valid"}, int'(vic_valid), ev);
    check({req, " no_alloc"}, int'(no_alloc), ena);
    if (ev) check({req, " vic_way"}, int'(vic_way), ew);
    @(negedge clk); acc_valid = 0;
  endtask

  task automatic idle_check(string req);
    @(negedge clk); acc_valid = 0;
    @(posedge clk); #1;
    check({req, " idle vic_valid"}, int'(vic_valid), 0);
    check({req, " idle no_alloc"}, int'(no_alloc), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int r;
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) stamp[s][w] = WAYS - 1 - w;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset vic_valid", int'(vic_valid), 0);
    check("R1 reset no_alloc", int'(no_alloc), 0);
    @(negedge clk); rst_n = 1;
    access(5, 0, 0, 0, 0, "R1");
    access(9, 0, 0, 0, 0, "R9");
    access(5, 0, 0, 0, 0, "R5");
    access(5, 1, 0, 0, 0, "R6");
    access(5, 0, 0, 0, 0, "R6 unchanged");
    idle_check("R8");
    access(6, 0, 1, 6, 0, "R4");
    access(6, 1, 0, 0, 5, "R2");
    access(6, 1, 0, 0, 5, "R2");
    access(6, 1, 1, 0, 5, "R4 foreign");
    access(6, 0, 0, 0, 5, "R10");
    access(6, 1, 0, 0, 6, "R7");
    access(6, 0, 0, 0, 7, "R7");
    r = 12345;
    for (int code = 0; code < 8; code++) begin
      for (int n = 0; n < 60; n++) begin
        r = (r * 1103515245 + 12345) & 32'h7fffffff;
        access(r % 4, (r >> 3) & 1, ((r >> 5) % 3) == 0, (r >> 8) % 8, code,
               code >= 6 ? "R7 sweep" : "R3 sweep");
      end
      idle_check("R8 sweep");
    end
    for (int code = 0; code < 6; code++)
      for (int t = 0; t < 2; t++)
        access(2, t, 0, 0, code, "R10 resplit");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule